// File: doc/BRIEF.md
# Single-Master Address-Decoding Bus Interconnect

This block joins one pipelined bus master to four slave ports. The bus carries 16-bit data and a stall line. The master presents a 20-bit word address. The two most significant bits of that address choose the slave, and the low 18 bits go to that slave as its local address. A slave that decodes fewer bits sees its contents repeat across its whole window. The write data and the write-enable go to every slave. Only the chosen slave sees its strobe. The acknowledge and read data from the slaves are steered back to the master.

Requests are pipelined. A request is accepted in a cycle where the master holds its strobe and the stall it sees is low. The index of each accepted request's slave goes into a small queue. Each acknowledge, together with its data, is taken from the slave at the head of that queue, and the entry is then removed. While requests to one slave are still unanswered, a request to another slave is held off by stall, so responses can never return out of order. When the master drops its cycle signal, the queue is emptied.

A slave position with no device behind it can be tied to acknowledge high, data zero and stall low. It then reads as zero and swallows writes. The block also distributes the common clock and active-low reset to the master and to every slave.

Top module: `icn_bus_decoder`

## Requirements
- R1: For slave index k, taken from master address bits [19:18], `s_stb[k]` is high only when `m_cyc`, `m_stb` and no hold-off (R4, R6) are all present. Every other `s_stb` bit is low, and all are low when `m_cyc` or `m_stb` is low.
- R2: Every slave port receives `m_adr[17:0]` as its local address, `m_wdata` as its write data and `m_we` as its write-enable.
- R3: When no hold-off applies, `m_stall` equals `s_stall[k]` of the addressed slave k, whether or not a strobe is present.
- R4: When at least one request is unanswered and the new address targets a different slave, `m_stall` is 1 and all `s_stb` bits are 0. Once the last outstanding request is answered, requests to the other slave flow again.
- R5: `m_ack` is 1 only when a request is outstanding and the slave that received the oldest unanswered request asserts its acknowledge. `m_rdata` then equals that slave's read data. An acknowledge from any other slave, or one arriving with nothing outstanding, leaves `m_ack` at 0.
- R6: At most PEND_DEPTH (default 4) requests can be unanswered at once. With that many outstanding, `m_stall` is 1 and no strobe is passed on. Each of them is later acknowledged exactly once.
- R7: While `m_cyc` is low, `m_ack` is 0. The clock edge with `m_cyc` low discards all outstanding requests, so later acknowledges of them are ignored and any slave can be addressed without hold-off.
- R8: A clock edge with `rst_n` low discards all outstanding requests in the same way.
- R9: `m_clk` and every bit of `s_clk` follow `clk`. `m_rst_n` and every bit of `s_rst_n` follow `rst_n`.
- R10: A slave port tied to acknowledge 1, data 0 and stall 0 completes each request in the cycle after acceptance, with `m_rdata` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Common synchronous active-low reset |
| m_cyc | input | 1 | Master bus cycle in progress |
| m_stb | input | 1 | Master request strobe |
| m_we | input | 1 | Master write-enable |
| m_adr | input | 20 | Master word address; bits [19:18] select the slave |
| m_wdata | input | 16 | Master write data |
| m_rdata | output | 16 | Read data returned to the master |
| m_ack | output | 1 | Acknowledge returned to the master |
| m_stall | output | 1 | Stall returned to the master |
| m_clk | output | 1 | Clock fanned out to the master |
| m_rst_n | output | 1 | Reset fanned out to the master |
| s_clk | output | 4 | Clock fanned out to each slave |
| s_rst_n | output | 4 | Reset fanned out to each slave |
| s_stb | output | 4 | Per-slave strobe |
| s_we | output | 4 | Per-slave write-enable |
| s_adr | output | 4x18 | Per-slave local word address |
| s_wdata | output | 4x16 | Per-slave write data |
| s_rdata | input | 4x16 | Per-slave read data |
| s_ack | input | 4 | Per-slave acknowledge |
| s_stall | input | 4 | Per-slave stall |

## Verification
The bench builds the block with its defaults: a 20-bit address, two select bits giving four slaves, 16-bit data and a four-entry pending queue. Slave 3 is tied off as an empty position.

With only four slaves and four stall bits, the bench can sweep every combination of selected slave, cycle, strobe and slave stall pattern against arithmetic expectations. The four-entry queue is small enough to be filled completely, so the full hold-off and the full drain can be checked directly. Directed sequences then cover a cross-slave hold-off with a wrong-slave acknowledge, a cycle drop, and a reset with a request still outstanding.

// File: rtl/icn_pkg.sv
// Package: icn_pkg
// Shared sizing helpers for the bus interconnect.
// Assumes: all sizes are positive integers.
package icn_pkg;

    // Width of an index able to address n items (never below 1).
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of a counter able to hold the value n.
    function automatic int cnt_w(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/icn_addr_decode.sv
// Module: icn_addr_decode
// Turns the selected slave index into a one-hot strobe vector.
// Assumes: req is already the AND of master cycle and strobe; block
// carries every reason to withhold the request this cycle.
module icn_addr_decode #(
    parameter int NUM_SLV = 4,
    parameter int IW      = 2
) (
    input  logic               req,
    input  logic               block,
    input  logic [IW-1:0]      sel,
    output logic [NUM_SLV-1:0] stb
);

    // One comparator per slave port; only the matching one may fire.
    for (genvar i = 0; i < NUM_SLV; i++) begin : g_stb
        assign stb[i] = req && !block && (sel == IW'(i));
    end

endmodule

// File: rtl/icn_owner_fifo.sv
// Module: icn_owner_fifo
// Circular queue of slave indices, one per accepted and unanswered request.
// Assumes: the caller never pushes when full nor pops when empty; flush
// and reset both empty the queue on the clock edge.
module icn_owner_fifo
    import icn_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IW    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [IW-1:0] push_idx,
    input  logic          pop,
    output logic          empty,
    output logic          full,
    output logic [IW-1:0] head_idx
);

    localparam int PW = idx_w(DEPTH);
    localparam int CW = cnt_w(DEPTH);

    logic [IW-1:0] slot_q [DEPTH];
    logic [PW-1:0] rd_q;
    logic [PW-1:0] wr_q;
    logic [CW-1:0] cnt_q;

    // Advance a pointer, wrapping at DEPTH-1 for any depth.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write: record the owner slave of each accepted request.
    always_ff @(posedge clk) begin
        if (push) begin
            slot_q[wr_q] <= push_idx;
        end
    end

    // Pointer and occupancy upkeep; reset and flush clear everything.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                wr_q <= bump(wr_q);
            end
            if (pop) begin
                rd_q <= bump(rd_q);
            end
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign empty    = (cnt_q == '0);
    assign full     = (cnt_q == CW'(DEPTH));
    assign head_idx = slot_q[rd_q];

endmodule

// File: rtl/icn_resp_mux.sv
// Module: icn_resp_mux
// Steers acknowledge and read data from the owner slave, and the stall
// from the addressed slave, back to the master.
// Assumes: head_idx is meaningful only while pending is high.
module icn_resp_mux #(
    parameter int NUM_SLV = 4,
    parameter int DATA_W  = 16,
    parameter int IW      = 2
) (
    input  logic                           m_cyc,
    input  logic                           pending,
    input  logic [IW-1:0]                  head_idx,
    input  logic [IW-1:0]                  sel,
    input  logic [NUM_SLV-1:0]             s_ack,
    input  logic [NUM_SLV-1:0]             s_stall,
    input  logic [NUM_SLV-1:0][DATA_W-1:0] s_rdata,
    output logic                           ack,
    output logic [DATA_W-1:0]              rdata,
    output logic                           sel_stall
);

    // Response path: only the owner of the oldest request may answer.
    always_comb begin
        ack   = m_cyc && pending && s_ack[head_idx];
        rdata = pending ? s_rdata[head_idx] : '0;
    end

    // Stall path: the stall of whichever slave the address points at.
    assign sel_stall = s_stall[sel];

endmodule

// File: rtl/icn_bus_decoder.sv
// Module: icn_bus_decoder
// One master to 2**SEL_W slaves over a pipelined strobe/stall/ack bus.
// The top SEL_W address bits pick the slave; the rest form the local
// address. Outstanding requests are tracked so responses stay in order.
// Assumes: single master; slaves acknowledge in request order and never
// in the cycle a request is accepted.
module icn_bus_decoder
    import icn_pkg::*;
#(
    parameter  int ADDR_W     = 20,
    parameter  int SEL_W      = 2,
    parameter  int DATA_W     = 16,
    parameter  int PEND_DEPTH = 4,
    localparam int NUM_SLV    = 1 << SEL_W,
    localparam int LOC_W      = ADDR_W - SEL_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           m_cyc,
    input  logic                           m_stb,
    input  logic                           m_we,
    input  logic [ADDR_W-1:0]              m_adr,
    input  logic [DATA_W-1:0]              m_wdata,
    output logic [DATA_W-1:0]              m_rdata,
    output logic                           m_ack,
    output logic                           m_stall,
    output logic                           m_clk,
    output logic                           m_rst_n,
    output logic [NUM_SLV-1:0]             s_clk,
    output logic [NUM_SLV-1:0]             s_rst_n,
    output logic [NUM_SLV-1:0]             s_stb,
    output logic [NUM_SLV-1:0]             s_we,
    output logic [NUM_SLV-1:0][LOC_W-1:0]  s_adr,
    output logic [NUM_SLV-1:0][DATA_W-1:0] s_wdata,
    input  logic [NUM_SLV-1:0][DATA_W-1:0] s_rdata,
    input  logic [NUM_SLV-1:0]             s_ack,
    input  logic [NUM_SLV-1:0]             s_stall
);

    localparam int IW = SEL_W;

    logic [IW-1:0] sel;
    logic          req;
    logic          q_empty;
    logic          q_full;
    logic [IW-1:0] head_idx;
    logic          conflict;
    logic          block;
    logic          sel_stall;
    logic          accept;

    // Request qualification and hold-off decision.
    always_comb begin
        sel      = m_adr[ADDR_W-1 -: SEL_W];
        req      = m_cyc && m_stb;
        conflict = !q_empty && (head_idx != sel);
        block    = conflict || q_full;
        m_stall  = block || sel_stall;
        accept   = req && !m_stall;
    end

    icn_addr_decode #(
        .NUM_SLV (NUM_SLV),
        .IW      (IW)
    ) decode_i (
        .req   (req),
        .block (block),
        .sel   (sel),
        .stb   (s_stb)
    );

    icn_owner_fifo #(
        .DEPTH (PEND_DEPTH),
        .IW    (IW)
    ) owner_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (!m_cyc),
        .push     (accept),
        .push_idx (sel),
        .pop      (m_ack),
        .empty    (q_empty),
        .full     (q_full),
        .head_idx (head_idx)
    );

    icn_resp_mux #(
        .NUM_SLV (NUM_SLV),
        .DATA_W  (DATA_W),
        .IW      (IW)
    ) resp_i (
        .m_cyc     (m_cyc),
        .pending   (!q_empty),
        .head_idx  (head_idx),
        .sel       (sel),
        .s_ack     (s_ack),
        .s_stall   (s_stall),
        .s_rdata   (s_rdata),
        .ack       (m_ack),
        .rdata     (m_rdata),
        .sel_stall (sel_stall)
    );

    // Master-side clock and reset fan-out.
    assign m_clk   = clk;
    assign m_rst_n = rst_n;

    // Per-slave broadcast of clock, reset, address, data and write-enable.
    for (genvar i = 0; i < NUM_SLV; i++) begin : g_slv
        assign s_clk[i]   = clk;
        assign s_rst_n[i] = rst_n;
        assign s_we[i]    = m_we;
        assign s_adr[i]   = m_adr[LOC_W-1:0];
        assign s_wdata[i] = m_wdata;
    end

endmodule

// File: rtl/icn_bus_decoder_chk.sv
// Module: icn_bus_decoder_chk
// Protocol checker for icn_bus_decoder, attached by bind. Keeps its own
// count of unanswered requests and the slave that owns them.
// Assumes: rst_n is low from time zero.
module icn_bus_decoder_chk
    import icn_pkg::*;
#(
    parameter int SEL_W      = 2,
    parameter int PEND_DEPTH = 4,
    parameter int NUM_SLV    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               m_cyc,
    input logic               m_stb,
    input logic [SEL_W-1:0]   sel,
    input logic               m_ack,
    input logic               m_stall,
    input logic [NUM_SLV-1:0] s_stb
);

    localparam int CW = cnt_w(PEND_DEPTH) + 1;

    logic [CW-1:0]    cnt_q;
    logic [SEL_W-1:0] owner_q;
    logic             acc;

    assign acc = m_cyc && m_stb && !m_stall;

    // Shadow count of outstanding requests and the slave they belong to.
    always_ff @(posedge clk) begin
        if (!rst_n || !m_cyc) begin
            cnt_q   <= '0;
            owner_q <= '0;
        end else begin
            if (acc) begin
                owner_q <= sel;
            end
            case ({acc, m_ack})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_stb)); // R1
    AST_STB_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (s_stb != '0) |-> (m_cyc && m_stb)); // R1
    AST_CROSS_SLAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cyc && m_stb && cnt_q != '0 && sel != owner_q) |-> (m_stall && s_stb == '0)); // R4
    AST_ACK_HAS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        m_ack |-> (cnt_q != '0)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(PEND_DEPTH)); // R6
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(PEND_DEPTH) && m_cyc && m_stb) |-> (m_stall && s_stb == '0)); // R6
    AST_ACK_NEEDS_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        m_ack |-> m_cyc); // R7

endmodule

bind icn_bus_decoder icn_bus_decoder_chk #(
    .SEL_W      (SEL_W),
    .PEND_DEPTH (PEND_DEPTH),
    .NUM_SLV    (NUM_SLV)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .m_cyc   (m_cyc),
    .m_stb   (m_stb),
    .sel     (m_adr[ADDR_W-1 -: SEL_W]),
    .m_ack   (m_ack),
    .m_stall (m_stall),
    .s_stb   (s_stb)
);

// File: tb/icn_bus_decoder_tb.sv
// Bench for icn_bus_decoder with default sizes; slave 3 is tied off.
module icn_bus_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int SW = 2;
    localparam int DW = 16;
    localparam int NS = 4;
    localparam int LW = AW - SW;
    localparam int DEPTH = 4;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   m_cyc = 1'b0;
    logic                   m_stb = 1'b0;
    logic                   m_we = 1'b0;
    logic [AW-1:0]          m_adr = '0;
    logic [DW-1:0]          m_wdata = '0;
    logic [DW-1:0]          m_rdata;
    logic                   m_ack;
    logic                   m_stall;
    logic                   m_clk;
    logic                   m_rst_n;
    logic [NS-1:0]          s_clk;
    logic [NS-1:0]          s_rst_n;
    logic [NS-1:0]          s_stb;
    logic [NS-1:0]          s_we;
    logic [NS-1:0][LW-1:0]  s_adr;
    logic [NS-1:0][DW-1:0]  s_wdata;
    logic [NS-1:0][DW-1:0]  s_rdata;
    logic [NS-1:0]          s_ack = 4'b1000;
    logic [NS-1:0]          s_stall = 4'b0000;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Slaves 0..2 return a fixed word; slave 3 is tied to zero.
    assign s_rdata[0] = 16'hA111;
    assign s_rdata[1] = 16'hB222;
    assign s_rdata[2] = 16'hC333;
    assign s_rdata[3] = 16'h0000;

    icn_bus_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we),
        .m_adr(m_adr), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack),
        .m_stall(m_stall), .m_clk(m_clk), .m_rst_n(m_rst_n), .s_clk(s_clk),
        .s_rst_n(s_rst_n), .s_stb(s_stb), .s_we(s_we), .s_adr(s_adr),
        .s_wdata(s_wdata), .s_rdata(s_rdata), .s_ack(s_ack), .s_stall(s_stall)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive a request (or idle) for slave k, then let outputs settle.
    task automatic drive(input int k, input logic stb);
        m_adr = {2'(k), 18'h0155A};
        m_stb = stb;
        #1;
    endtask

    task automatic next_cycle();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // Reset state: fan-out of reset and clock, no acknowledge.
        #1;
        check("R9 s_rst_n in reset", 32'(s_rst_n), 32'h0);
        check("R9 m_rst_n in reset", 32'(m_rst_n), 32'h0);
        check("R9 s_clk low phase", 32'(s_clk), 32'h0);
        check("R9 m_clk low phase", 32'(m_clk), 32'h0);
        check("R8 no ack in reset", 32'(m_ack), 32'h0);
        @(posedge clk); #1;
        check("R9 s_clk high phase", 32'(s_clk), 32'hF);
        check("R9 m_clk high phase", 32'(m_clk), 32'h1);
        repeat (2) next_cycle();
        rst_n = 1'b1;
        m_cyc = 1'b1;
        #1;
        check("R9 s_rst_n released", 32'(s_rst_n), 32'hF);
        check("R9 m_rst_n released", 32'(m_rst_n), 32'h1);
        next_cycle();

        // Sweep: slave, cycle, strobe, every stall pattern; nothing accepted.
        for (int k = 0; k < NS; k++) begin
            for (int cs = 0; cs < 4; cs++) begin
                for (int sp = 0; sp < 16; sp++) begin
                    logic [LW-1:0] loc;
                    loc = LW'((k * 16 + sp) * 4099 + cs * 771);
                    m_cyc = cs[1];
                    m_stb = cs[0];
                    m_we = sp[0] ^ cs[0];
                    m_adr = {2'(k), loc};
                    m_wdata = 16'((sp * 3011) ^ (k << 12));
                    s_stall = 4'(sp);
                    #1;
                    check("R1 strobe select", 32'(s_stb), (cs == 3) ? 32'(1 << k) : 32'h0);
                    check("R3 stall passthrough", 32'(m_stall), 32'((sp >> k) & 1));
                    check("R5 no ack when idle", 32'(m_ack), 32'h0);
                    for (int j = 0; j < NS; j++) begin
                        check("R2 local address", 32'(s_adr[j]), 32'(loc));
                        check("R2 write data", 32'(s_wdata[j]), 32'(m_wdata));
                    end
                    check("R2 write enable", 32'(s_we), m_we ? 32'hF : 32'h0);
                    m_stb = 1'b0;
                    next_cycle();
                end
            end
        end
        m_cyc = 1'b1;
        s_stall = 4'b0000;
        next_cycle();

        // Tied-off slave 3: reads zero, acknowledged next cycle.
        drive(3, 1'b1);
        check("R10 strobe to slave 3", 32'(s_stb), 32'h8);
        next_cycle();
        drive(3, 1'b0);
        check("R10 tied-off ack", 32'(m_ack), 32'h1);
        check("R10 tied-off data", 32'(m_rdata), 32'h0);
        next_cycle();
        #1;
        check("R10 single ack", 32'(m_ack), 32'h0);

        // Ordering: slave 1 outstanding blocks slave 2; wrong ack ignored.
        next_cycle();
        drive(1, 1'b1);
        check("R1 strobe slave 1", 32'(s_stb), 32'h2);
        next_cycle();
        s_ack = 4'b1100;
        drive(2, 1'b1);
        check("R4 cross-slave stall", 32'(m_stall), 32'h1);
        check("R4 cross-slave no strobe", 32'(s_stb), 32'h0);
        check("R5 wrong-slave ack ignored", 32'(m_ack), 32'h0);
        next_cycle();
        s_ack = 4'b1010;
        drive(2, 1'b0);
        check("R5 owner ack", 32'(m_ack), 32'h1);
        check("R5 owner data", 32'(m_rdata), 32'hB222);
        next_cycle();
        s_ack = 4'b1000;
        drive(2, 1'b1);
        check("R4 released stall", 32'(m_stall), 32'h0);
        check("R4 released strobe", 32'(s_stb), 32'h4);
        next_cycle();
        s_ack = 4'b1100;
        drive(2, 1'b0);
        check("R5 slave 2 ack", 32'(m_ack), 32'h1);
        check("R5 slave 2 data", 32'(m_rdata), 32'hC333);
        next_cycle();
        s_ack = 4'b1000;

        // Depth: fill PEND_DEPTH requests to slave 0, then drain.
        for (int n = 0; n < DEPTH; n++) begin
            drive(0, 1'b1);
            check("R6 accept while not full", 32'(m_stall), 32'h0);
            next_cycle();
        end
        drive(0, 1'b1);
        check("R6 full stall", 32'(m_stall), 32'h1);
        check("R6 full no strobe", 32'(s_stb), 32'h0);
        next_cycle();
        s_ack = 4'b1001;
        for (int n = 0; n < DEPTH; n++) begin
            drive(0, 1'b0);
            check("R6 drain ack", 32'(m_ack), 32'h1);
            check("R6 drain data", 32'(m_rdata), 32'hA111);
            next_cycle();
        end
        #1;
        check("R6 drained, no extra ack", 32'(m_ack), 32'h0);
        s_ack = 4'b1000;
        next_cycle();

        // Cycle drop discards the outstanding request to slave 1.
        drive(1, 1'b1);
        next_cycle();
        m_cyc = 1'b0;
        s_ack = 4'b1010;
        drive(1, 1'b0);
        check("R7 no ack without cycle", 32'(m_ack), 32'h0);
        next_cycle();
        m_cyc = 1'b1;
        drive(2, 1'b1);
        check("R7 stray ack ignored", 32'(m_ack), 32'h0);
        check("R7 no hold-off after drop", 32'(m_stall), 32'h0);
        m_stb = 1'b0;
        s_ack = 4'b1000;
        next_cycle();

        // Reset discards the outstanding request to slave 1.
        drive(1, 1'b1);
        next_cycle();
        rst_n = 1'b0;
        drive(1, 1'b0);
        next_cycle();
        rst_n = 1'b1;
        s_ack = 4'b1010;
        drive(2, 1'b1);
        check("R8 stray ack after reset", 32'(m_ack), 32'h0);
        check("R8 no hold-off after reset", 32'(m_stall), 32'h0);
        m_stb = 1'b0;
        s_ack = 4'b1000;
        next_cycle();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule